// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port synchronous memory. Two independent ports, A and B, each run on their own clock. Each port has a pair of chip selects, a read/write strobe, an asynchronous output enable, an address bus and separate data-in and data-out buses. The high-impedance state of a real output pin is shown by a per-port output-valid flag.

Each port has its own burst address counter. On every rising edge of that port's clock, the counter can be cleared, loaded from the external address, advanced by one, or held. The address used for an access is the value the counter takes on that same edge. A load or clear therefore takes effect in the cycle it is issued. A per-port latency select sets read data to appear either after the edge that registers the address (flow-through) or one edge later (pipelined).

Depth and data width are parameters. A nine-bit width and an eight-bit width are both supported. Arbitration between the ports is not provided. A same-address write on both ports in the same cycle leaves that word undefined.

Top module: `dp_burst_ram`

## Requirements
- R1: A port is selected only when `cs_x_ni` is 0 and `cs_x_i` is 1. A deselected port performs no write, and in flow-through mode its `valid_x_o` is 0 after that edge.
- R2: On a rising edge with the port selected and `rdwr_x_i` = 0, `din_x_i` is written to the word at the port's access address.
- R3: In flow-through mode (`lat2_x_i` = 0), a selected read (`rdwr_x_i` = 1) on edge k drives the addressed word on `dout_x_o`, with `valid_x_o` = 1, from edge k until edge k+1.
- R4: In pipelined mode (`lat2_x_i` = 1), a read on edge k shows its data and `valid_x_o` = 1 only after edge k+1. After edge k itself, the flag still reflects the access before it.
- R5: While `oe_x_ni` = 1, `valid_x_o` is 0 at once, without waiting for any clock edge. Returning `oe_x_ni` to 0 restores the flag without a clock edge.
- R6: `clr_x_ni` = 0 forces the counter to address 0. It has top priority, above the load and advance controls.
- R7: When `clr_x_ni` = 1 and `ld_x_ni` = 0, the counter takes `addr_x_i`. This has priority over `adv_x_ni`.
- R8: When `clr_x_ni` = 1, `ld_x_ni` = 1 and `adv_x_ni` = 0, the counter increments by one. It wraps from the top address to 0.
- R9: With all three counter controls at 1, the counter keeps its previous value.
- R10: The counter controls act on every edge whether or not the port is selected.
- R11: An access uses the counter value produced on the same edge, so a load or clear steers that edge's read or write.
- R12: The output data register holds its value across cycles with no read. Only `valid_x_o` drops, with the selected latency.
- R13: A word written on one port is returned by a read on the other port from the reader's next edge. A read on the same edge returns the old word.
- R14: During and after reset, both counters are 0, both valid flags are 0 and every word reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_a_i | input | 1 | Port A clock |
| cs_a_ni | input | 1 | Port A chip select, active low |
| cs_a_i | input | 1 | Port A chip select, active high |
| rdwr_a_i | input | 1 | Port A: 1 read, 0 write |
| oe_a_ni | input | 1 | Port A output enable, active low, asynchronous |
| addr_a_i | input | ADDR_W | Port A external address |
| din_a_i | input | DATA_W | Port A write data |
| ld_a_ni | input | 1 | Port A counter load, active low |
| adv_a_ni | input | 1 | Port A counter advance, active low |
| clr_a_ni | input | 1 | Port A counter clear, active low |
| lat2_a_i | input | 1 | Port A: 1 pipelined, 0 flow-through |
| dout_a_o | output | DATA_W | Port A read data |
| valid_a_o | output | 1 | Port A output driven |
| clk_b_i | input | 1 | Port B clock |
| cs_b_ni | input | 1 | Port B chip select, active low |
| cs_b_i | input | 1 | Port B chip select, active high |
| rdwr_b_i | input | 1 | Port B: 1 read, 0 write |
| oe_b_ni | input | 1 | Port B output enable, active low, asynchronous |
| addr_b_i | input | ADDR_W | Port B external address |
| din_b_i | input | DATA_W | Port B write data |
| ld_b_ni | input | 1 | Port B counter load, active low |
| adv_b_ni | input | 1 | Port B counter advance, active low |
| clr_b_ni | input | 1 | Port B counter clear, active low |
| lat2_b_i | input | 1 | Port B: 1 pipelined, 0 flow-through |
| dout_b_o | output | DATA_W | Port B read data |
| valid_b_o | output | 1 | Port B output driven |

## Verification
On every cycle, the assertions check the output-valid flag of each port against select, read/write and output enable at both latencies. They also check that the output data holds through cycles with no read. The counter is internal, so its priority, wrap and behaviour while deselected can only be seen in the bench's scenarios, through the data read back. The same applies to the same-edge use of a loaded address, cross-port visibility and the cleared reset contents.

// File: rtl/dp_burst_ram_pkg.sv
package dp_burst_ram_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_INC  = 2'd1,
    CTR_LOAD = 2'd2,
    CTR_CLR  = 2'd3
  } ctr_op_e;

  function automatic ctr_op_e ctr_decode(input logic clr_n, input logic ld_n,
                                         input logic adv_n);
    if (!clr_n)      return CTR_CLR;
    else if (!ld_n)  return CTR_LOAD;
    else if (!adv_n) return CTR_INC;
    else             return CTR_HOLD;
  endfunction
endpackage

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import dp_burst_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              ld_ni,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_nxt_o
);
  logic [ADDR_W-1:0] addr_q;
  ctr_op_e           op;

  assign op = ctr_decode(clr_ni, ld_ni, adv_ni);

  always_comb begin
    unique case (op)
      CTR_CLR:  addr_nxt_o = '0;
      CTR_LOAD: addr_nxt_o = ext_addr_i;
      CTR_INC:  addr_nxt_o = addr_q + ADDR_W'(1); // wraps naturally
      default:  addr_nxt_o = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_nxt_o;
  end
endmodule

// File: rtl/port_rd_path.sv
module port_rd_path #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic              lat2_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] s1_q, s2_q;
  logic              v1_q, v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= rd_en_i;
      v2_q <= v1_q;
      if (rd_en_i) s1_q <= rd_word_i;
      if (v1_q)    s2_q <= s1_q;
    end
  end

  // output enable is combinational on purpose
  assign dout_o  = lat2_i ? s2_q : s1_q;
  assign valid_o = !oe_ni && (lat2_i ? v2_q : v1_q);
endmodule

// File: rtl/mem_bank.sv
module mem_bank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9,
  parameter int N_RD   = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_RD-1:0][ADDR_W-1:0] raddr_i,
  output logic [N_RD-1:0][DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/dp_port.sv
module dp_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              cs_i,
  input  logic              rdwr_i,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_ni,
  input  logic              adv_ni,
  input  logic              clr_ni,
  input  logic              lat2_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  logic sel, rd_en;

  assign sel     = !cs_ni && cs_i;
  assign wr_en_o = sel && !rdwr_i;
  assign rd_en   = sel && rdwr_i;

  burst_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_ni     (clr_ni),
    .ld_ni      (ld_ni),
    .adv_ni     (adv_ni),
    .ext_addr_i (addr_i),
    .addr_nxt_o (acc_addr_o)
  );

  port_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en),
    .rd_word_i (rd_word_i),
    .lat2_i    (lat2_i),
    .oe_ni     (oe_ni),
    .dout_o    (dout_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/dp_burst_ram.sv
module dp_burst_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              rst_ni,
  input  logic              clk_a_i,
  input  logic              cs_a_ni,
  input  logic              cs_a_i,
  input  logic              rdwr_a_i,
  input  logic              oe_a_ni,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] din_a_i,
  input  logic              ld_a_ni,
  input  logic              adv_a_ni,
  input  logic              clr_a_ni,
  input  logic              lat2_a_i,
  output logic [DATA_W-1:0] dout_a_o,
  output logic              valid_a_o,
  input  logic              clk_b_i,
  input  logic              cs_b_ni,
  input  logic              cs_b_i,
  input  logic              rdwr_b_i,
  input  logic              oe_b_ni,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] din_b_i,
  input  logic              ld_b_ni,
  input  logic              adv_b_ni,
  input  logic              clr_b_ni,
  input  logic              lat2_b_i,
  output logic [DATA_W-1:0] dout_b_o,
  output logic              valid_b_o
);
  localparam int NP = 2;

  logic [NP-1:0]             clk_p, cs_n_p, cs_p, rdwr_p, oe_n_p;
  logic [NP-1:0]             ld_n_p, adv_n_p, clr_n_p, lat2_p, wr_en, valid_p;
  logic [NP-1:0][ADDR_W-1:0] addr_p, acc_addr;
  logic [NP-1:0][DATA_W-1:0] din_p, dout_p, rd_word;
  // bank_rd[bank][port]: word of each bank at each port's access address
  logic [NP-1:0][NP-1:0][DATA_W-1:0] bank_rd;

  assign clk_p   = {clk_b_i,  clk_a_i};
  assign cs_n_p  = {cs_b_ni,  cs_a_ni};
  assign cs_p    = {cs_b_i,   cs_a_i};
  assign rdwr_p  = {rdwr_b_i, rdwr_a_i};
  assign oe_n_p  = {oe_b_ni,  oe_a_ni};
  assign ld_n_p  = {ld_b_ni,  ld_a_ni};
  assign adv_n_p = {adv_b_ni, adv_a_ni};
  assign clr_n_p = {clr_b_ni, clr_a_ni};
  assign lat2_p  = {lat2_b_i, lat2_a_i};
  assign addr_p  = {addr_b_i, addr_a_i};
  assign din_p   = {din_b_i,  din_a_i};

  assign dout_a_o  = dout_p[0];
  assign dout_b_o  = dout_p[1];
  assign valid_a_o = valid_p[0];
  assign valid_b_o = valid_p[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    // one bank per writing clock; stored word is the XOR of both banks
    mem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RD(NP)) u_bank (
      .clk_i   (clk_p[p]),
      .rst_ni  (rst_ni),
      .we_i    (wr_en[p]),
      .waddr_i (acc_addr[p]),
      .wdata_i (din_p[p] ^ bank_rd[NP-1-p][p]),
      .raddr_i (acc_addr),
      .rdata_o (bank_rd[p])
    );

    assign rd_word[p] = bank_rd[0][p] ^ bank_rd[1][p];

    dp_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk_i      (clk_p[p]),
      .rst_ni     (rst_ni),
      .cs_ni      (cs_n_p[p]),
      .cs_i       (cs_p[p]),
      .rdwr_i     (rdwr_p[p]),
      .oe_ni      (oe_n_p[p]),
      .addr_i     (addr_p[p]),
      .ld_ni      (ld_n_p[p]),
      .adv_ni     (adv_n_p[p]),
      .clr_ni     (clr_n_p[p]),
      .lat2_i     (lat2_p[p]),
      .rd_word_i  (rd_word[p]),
      .acc_addr_o (acc_addr[p]),
      .wr_en_o    (wr_en[p]),
      .dout_o     (dout_p[p]),
      .valid_o    (valid_p[p])
    );
  end
endmodule

// File: rtl/dp_burst_ram_chk.sv
module dp_burst_ram_chk #(
  parameter int DATA_W = 9
) (
  input logic              rst_ni,
  input logic              clk_a_i,
  input logic              cs_a_ni,
  input logic              cs_a_i,
  input logic              rdwr_a_i,
  input logic              oe_a_ni,
  input logic              lat2_a_i,
  input logic [DATA_W-1:0] dout_a_o,
  input logic              valid_a_o,
  input logic              clk_b_i,
  input logic              cs_b_ni,
  input logic              cs_b_i,
  input logic              rdwr_b_i,
  input logic              oe_b_ni,
  input logic              lat2_b_i,
  input logic [DATA_W-1:0] dout_b_o,
  input logic              valid_b_o
);
  logic rd_a, rd_b;
  assign rd_a = !cs_a_ni && cs_a_i && rdwr_a_i;
  assign rd_b = !cs_b_ni && cs_b_i && rdwr_b_i;

  // R5
  a_oe_gate_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    valid_a_o |-> !oe_a_ni);
  // R5
  b_oe_gate_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    valid_b_o |-> !oe_b_ni);
  // R3
  a_flow_read_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (rd_a && !lat2_a_i) |=> (valid_a_o || oe_a_ni || lat2_a_i));
  // R3
  b_flow_read_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (rd_b && !lat2_b_i) |=> (valid_b_o || oe_b_ni || lat2_b_i));
  // R1
  a_flow_idle_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!rd_a && !lat2_a_i) |=> (!valid_a_o || lat2_a_i));
  // R1
  b_flow_idle_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!rd_b && !lat2_b_i) |=> (!valid_b_o || lat2_b_i));
  // R4
  a_pipe_read_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    rd_a |=> ##1 (valid_a_o || oe_a_ni || !lat2_a_i));
  // R4
  b_pipe_read_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    rd_b |=> ##1 (valid_b_o || oe_b_ni || !lat2_b_i));
  // R12
  a_hold_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!rd_a && !lat2_a_i) |=> (lat2_a_i || $stable(dout_a_o)));
  // R12
  b_hold_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!rd_b && !lat2_b_i) |=> (lat2_b_i || $stable(dout_b_o)));
endmodule

bind dp_burst_ram dp_burst_ram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dp_burst_ram_bench.sv
module dp_burst_ram_bench;
  localparam int AW = 6;
  localparam int DW = 9;
  localparam int NV = 8;

  // vector: {address, data}; written on A, read back on B
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {6'd5,  9'h1A5}, {6'd6,  9'h0C6}, {6'd7,  9'h137}, {6'd8,  9'h048},
    {6'd63, 9'h1FF}, {6'd0,  9'h0A0}, {6'd20, 9'h114}, {6'd33, 9'h021}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_a_ni = 1'b1, cs_a_i = 1'b1, rdwr_a_i = 1'b1, oe_a_ni = 1'b0;
  logic ld_a_ni = 1'b1, adv_a_ni = 1'b1, clr_a_ni = 1'b1, lat2_a_i = 1'b0;
  logic [AW-1:0] addr_a_i = '0;
  logic [DW-1:0] din_a_i = '0;
  logic cs_b_ni = 1'b1, cs_b_i = 1'b1, rdwr_b_i = 1'b1, oe_b_ni = 1'b0;
  logic ld_b_ni = 1'b1, adv_b_ni = 1'b1, clr_b_ni = 1'b1, lat2_b_i = 1'b0;
  logic [AW-1:0] addr_b_i = '0;
  logic [DW-1:0] din_b_i = '0;
  logic [DW-1:0] dout_a_o, dout_b_o;
  logic valid_a_o, valid_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dp_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dp_burst_ram (
    .rst_ni, .clk_a_i(clk), .cs_a_ni, .cs_a_i, .rdwr_a_i, .oe_a_ni, .addr_a_i,
    .din_a_i, .ld_a_ni, .adv_a_ni, .clr_a_ni, .lat2_a_i, .dout_a_o, .valid_a_o,
    .clk_b_i(clk), .cs_b_ni, .cs_b_i, .rdwr_b_i, .oe_b_ni, .addr_b_i,
    .din_b_i, .ld_b_ni, .adv_b_ni, .clr_b_ni, .lat2_b_i, .dout_b_o, .valid_b_o
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle on a port; returns just after the rising edge
  task automatic cyc_a(input logic csn, input logic cs, input logic rd,
                       input logic ldn, input logic advn, input logic clrn,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs_a_ni = csn; cs_a_i = cs; rdwr_a_i = rd; ld_a_ni = ldn;
    adv_a_ni = advn; clr_a_ni = clrn; addr_a_i = a; din_a_i = d;
    @(posedge clk); #1;
  endtask

  task automatic cyc_b(input logic csn, input logic cs, input logic rd,
                       input logic ldn, input logic advn, input logic clrn,
                       input logic [AW-1:0] a);
    @(negedge clk);
    cs_b_ni = csn; cs_b_i = cs; rdwr_b_i = rd; ld_b_ni = ldn;
    adv_b_ni = advn; clr_b_ni = clrn; addr_b_i = a;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    #5;
    // R14 valid flags low in reset
    check("R14 valid_a in reset", DW'(valid_a_o), DW'(0));
    check("R14 valid_b in reset", DW'(valid_b_o), DW'(0));
    @(negedge clk); rst_ni = 1'b1;

    // R14 cleared contents; R6 clear steers the same-edge read
    cyc_b(0, 1, 1, 1, 1, 0, 6'd9);
    check("R14 word 0 after reset", dout_b_o, 9'h000);
    check("R3 valid after flow read", DW'(valid_b_o), DW'(1));

    // R2 R7 R11 vector writes on A with load
    for (int i = 0; i < NV; i++)
      cyc_a(0, 1, 0, 0, 1, 1, VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    // R3 R7 R11 read back on B
    for (int i = 0; i < NV; i++) begin
      cyc_b(0, 1, 1, 0, 1, 1, VEC[i][AW+DW-1:DW]);
      check($sformatf("R3 R11 vector %0d", i), dout_b_o, VEC[i][DW-1:0]);
    end

    // R8 R9 burst
    cyc_b(0, 1, 1, 0, 1, 1, 6'd5);
    check("R7 load 5", dout_b_o, 9'h1A5);
    cyc_b(0, 1, 1, 1, 0, 1, 6'd0);
    check("R8 advance to 6", dout_b_o, 9'h0C6);
    cyc_b(0, 1, 1, 1, 0, 1, 6'd0);
    check("R8 advance to 7", dout_b_o, 9'h137);
    cyc_b(0, 1, 1, 1, 1, 1, 6'd0);
    check("R9 hold at 7", dout_b_o, 9'h137);

    // R6 R7 priority
    cyc_b(0, 1, 1, 0, 0, 0, 6'd20);
    check("R6 clear over load", dout_b_o, 9'h0A0);
    cyc_b(0, 1, 1, 0, 0, 1, 6'd20);
    check("R7 load over advance", dout_b_o, 9'h114);

    // R8 wrap
    cyc_b(0, 1, 1, 0, 1, 1, 6'd63);
    check("R8 load top", dout_b_o, 9'h1FF);
    cyc_b(0, 1, 1, 1, 0, 1, 6'd0);
    check("R8 wrap to 0", dout_b_o, 9'h0A0);

    // R10 counter moves while deselected; R1 both select pins
    cyc_b(0, 1, 1, 0, 1, 1, 6'd5);
    cyc_b(1, 1, 1, 1, 0, 1, 6'd0);
    check("R1 cs_n high deselects", DW'(valid_b_o), DW'(0));
    cyc_b(0, 0, 1, 1, 0, 1, 6'd0);
    check("R1 cs low deselects", DW'(valid_b_o), DW'(0));
    cyc_b(0, 1, 1, 1, 1, 1, 6'd0);
    check("R10 advance while deselected", dout_b_o, 9'h137);
    cyc_b(1, 1, 1, 0, 1, 1, 6'd33);
    cyc_b(0, 1, 1, 1, 1, 1, 6'd0);
    check("R10 load while deselected", dout_b_o, 9'h021);

    // R12 data held, flag dropped
    cyc_b(1, 1, 1, 1, 1, 1, 6'd0);
    check("R12 flow valid drops", DW'(valid_b_o), DW'(0));
    check("R12 flow data held", dout_b_o, 9'h021);

    // R5 async output enable
    cyc_b(0, 1, 1, 1, 1, 1, 6'd0);
    check("R5 valid before oe", DW'(valid_b_o), DW'(1));
    oe_b_ni = 1'b1; #1;
    check("R5 oe high drops valid", DW'(valid_b_o), DW'(0));
    oe_b_ni = 1'b0; #1;
    check("R5 oe low restores valid", DW'(valid_b_o), DW'(1));

    // R1 R2 deselected write ignored
    cyc_a(1, 1, 0, 0, 1, 1, 6'd5, 9'h0FF);
    cyc_a(0, 0, 0, 0, 1, 1, 6'd5, 9'h0EE);
    cyc_b(0, 1, 1, 0, 1, 1, 6'd5);
    check("R1 no write when deselected", dout_b_o, 9'h1A5);

    // R4 R12 pipelined on A
    lat2_a_i = 1'b1;
    cyc_a(1, 1, 1, 1, 1, 1, 6'd0, 9'h000);
    cyc_a(0, 1, 1, 0, 1, 1, 6'd20, 9'h000);
    check("R4 not yet valid after first edge", DW'(valid_a_o), DW'(0));
    cyc_a(1, 1, 1, 1, 1, 1, 6'd0, 9'h000);
    check("R4 valid after second edge", DW'(valid_a_o), DW'(1));
    check("R4 pipelined data", dout_a_o, 9'h114);
    cyc_a(1, 1, 1, 1, 1, 1, 6'd0, 9'h000);
    check("R12 pipe valid drops", DW'(valid_a_o), DW'(0));
    check("R12 pipe data held", dout_a_o, 9'h114);
    lat2_a_i = 1'b0;

    // R13 same-edge write A / read B, then next edge
    @(negedge clk);
    cs_a_ni = 0; cs_a_i = 1; rdwr_a_i = 0; ld_a_ni = 0; adv_a_ni = 1;
    clr_a_ni = 1; addr_a_i = 6'd40; din_a_i = 9'h155;
    cs_b_ni = 0; cs_b_i = 1; rdwr_b_i = 1; ld_b_ni = 0; adv_b_ni = 1;
    clr_b_ni = 1; addr_b_i = 6'd40;
    @(posedge clk); #1;
    check("R13 same edge reads old", dout_b_o, 9'h000);
    cs_a_ni = 1;
    cyc_b(0, 1, 1, 1, 1, 1, 6'd0);
    check("R13 next edge reads new", dout_b_o, 9'h155);

    // R2 write from B, read on A
    cyc_b(0, 1, 0, 0, 1, 1, 6'd41);
    din_b_i = 9'h0AB;
    cyc_b(0, 1, 0, 0, 1, 1, 6'd41);
    cyc_a(0, 1, 1, 0, 1, 1, 6'd41, 9'h000);
    check("R2 port B write seen on A", dout_a_o, 9'h0AB);

    done = 1'b1;
    finish_run();
  end
endmodule